// File: doc/BRIEF.md
# Prime-Modulo Banked Word Memory

This block stores 24 data words spread over three independent banks of eight words each. A linear word address picks its bank as the address modulo 3 and its slot inside that bank as the address modulo 8. Three and eight share no common factor, so each address from 0 to 23 lands on its own (bank, slot) pair. No divider is needed anywhere. The modulo-3 reduction folds the address in 2-bit groups, because four leaves a remainder of one when divided by three. The slot is simply the low three address bits.

The block takes at most one read or write per clock. An accepted request keeps its bank occupied for a fixed number of cycles, set by the `LATENCY` parameter. A request that targets an occupied bank is refused through `req_ready` and must be held by the requester. Every refused cycle adds one to a conflict counter. With a prime bank count, power-of-two strides rotate through all the banks instead of piling onto one. Addresses at or above 24 are flagged and otherwise ignored.

Top module: `prime_bank_mapper`

## Requirements
- R1: `map_bank` equals `req_addr` modulo 3 for every address 0..23.
- R2: `map_offset` equals `req_addr` modulo 8 for every address 0..23. Because the pairs are unique, writing 24 distinct words to addresses 0..23 and reading them back returns each word unchanged.
- R3: Address 5 maps to bank 2, slot 5.
- R4: An accepted read raises `rd_valid` with the stored word in the cycle right after the accepting clock edge. `rd_valid` is low at all other times.
- R5: An accepted request occupies its bank for `LATENCY` cycles (default 3). A request to an occupied bank sees `req_ready` low and is not accepted until the bank frees.
- R6: `conflict_cnt` increments by one for every clock edge on which a valid in-range request is refused.
- R7: With `LATENCY` 3, a back-to-back stride-1 stream and a stride-8 stream (taken modulo 24) run with no refusals. A stride-3 stream of four accesses to one bank is refused for 6 cycles in total.
- R8: An address of 24 or above raises `range_err` while it is presented and keeps `req_ready` high. It writes nothing, returns no read data and does not occupy any bank. For example, a write to 29 leaves word 5 unchanged.
- R9: After reset, `req_ready` is 1, `rd_valid` is 0 and `conflict_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Linear word address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | 0 when the request is refused because its bank is occupied |
| range_err | output | 1 | Valid request with address of 24 or above |
| map_bank | output | 2 | Bank chosen for `req_addr` |
| map_offset | output | 3 | Slot inside the bank for `req_addr` |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 16 | Read data |
| conflict_cnt | output | 16 | Count of refused cycles (wraps) |

## Verification
The assertions assume that a refused request is held unchanged until it is accepted, and that address and control inputs carry no unknown bits once reset is released. The driver task presents each request at a falling edge and keeps it on the pins until `req_ready` is seen high. It only ever drives fully known values. Out-of-range addresses are presented deliberately, since the block defines a response to them.

// File: rtl/pmm_pkg.sv
package pmm_pkg;
    localparam int NUM_BANKS  = 3;
    localparam int BANK_WORDS = 8;
    localparam int NUM_WORDS  = NUM_BANKS * BANK_WORDS;
    localparam int ADDR_W     = $clog2(NUM_WORDS);
    localparam int BANK_W     = $clog2(NUM_BANKS);
    localparam int OFF_W      = $clog2(BANK_WORDS);
    localparam int DATA_W     = 16;
    localparam int PAD_W      = ADDR_W + (ADDR_W % 2);
    localparam int GROUPS     = PAD_W / 2;
    localparam int FOLDS      = 3;

    typedef struct packed {
        logic              in_range;
        logic [BANK_W-1:0] bank;
        logic [OFF_W-1:0]  offset;
    } map_t;

    // residue modulo 3: 4^k leaves 1, so sum base-4 digits and fold again
    function automatic logic [BANK_W-1:0] mod3(input logic [ADDR_W-1:0] a);
        logic [PAD_W-1:0] s;
        logic [PAD_W-1:0] t;
        s = PAD_W'(a);
        for (int f = 0; f < FOLDS; f++) begin
            t = '0;
            for (int g = 0; g < GROUPS; g++)
                t = t + PAD_W'(s[2*g +: 2]);
            s = t;
        end
        return (s[1:0] == 2'd3) ? 2'd0 : s[1:0];
    endfunction
endpackage

// File: rtl/pmm_addr_map.sv
module pmm_addr_map
    import pmm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    output map_t              loc
);
    always_comb begin
        loc.in_range = (addr < ADDR_W'(NUM_WORDS));
        loc.bank     = mod3(addr);
        loc.offset   = addr[OFF_W-1:0];
    end

    assert_bank_lt3_R1: assert property (@(posedge clk) disable iff (rst)
        loc.in_range |-> (loc.bank < BANK_W'(NUM_BANKS)));
endmodule

// File: rtl/pmm_bank.sv
module pmm_bank
    import pmm_pkg::*;
#(
    parameter int LATENCY = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              we,
    input  logic [OFF_W-1:0]  offset,
    input  logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata
);
    localparam int CNT_W = $clog2(LATENCY + 1);

    logic [DATA_W-1:0] mem [BANK_WORDS];
    logic [CNT_W-1:0]  busy_cnt;
    logic              acc;

    assign busy = (busy_cnt != '0);
    assign acc  = sel && !busy;

    always_ff @(posedge clk) begin
        if (rst)
            busy_cnt <= '0;
        else if (acc)
            busy_cnt <= CNT_W'(LATENCY - 1);
        else if (busy)
            busy_cnt <= busy_cnt - CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (acc && we)
            mem[offset] <= wdata;
        if (acc && !we)
            rdata <= mem[offset];
    end

    always_ff @(posedge clk) begin
        if (rst) rvalid <= 1'b0;
        else     rvalid <= acc && !we;
    end

    assert_occupy_R5: assert property (@(posedge clk) disable iff (rst)
        acc |=> (busy_cnt == CNT_W'(LATENCY - 1)));
    assert_refused_R5: assert property (@(posedge clk) disable iff (rst)
        (sel && busy) |=> (rvalid == 1'b0));
endmodule

// File: rtl/prime_bank_mapper.sv
module prime_bank_mapper
    import pmm_pkg::*;
#(
    parameter int LATENCY = 3,
    parameter int CONF_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [4:0]        req_addr,
    input  logic [15:0]       req_wdata,
    output logic              req_ready,
    output logic              range_err,
    output logic [1:0]        map_bank,
    output logic [2:0]        map_offset,
    output logic              rd_valid,
    output logic [15:0]       rd_data,
    output logic [CONF_W-1:0] conflict_cnt
);
    map_t                loc;
    logic [NUM_BANKS-1:0] sel, busy, rv;
    logic [DATA_W-1:0]    rd [NUM_BANKS];
    logic                 stall;

    pmm_addr_map map_i (.clk(clk), .rst(rst), .addr(req_addr), .loc(loc));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign sel[b] = req_valid && loc.in_range && (loc.bank == BANK_W'(b));
        pmm_bank #(.LATENCY(LATENCY)) bank_i (
            .clk(clk), .rst(rst), .sel(sel[b]), .we(req_we),
            .offset(loc.offset), .wdata(req_wdata),
            .busy(busy[b]), .rvalid(rv[b]), .rdata(rd[b]));
    end

    assign stall      = |(sel & busy);
    assign req_ready  = !stall;
    assign range_err  = req_valid && !loc.in_range;
    assign map_bank   = loc.bank;
    assign map_offset = loc.offset;
    assign rd_valid   = |rv;

    always_comb begin
        rd_data = '0;
        for (int b = 0; b < NUM_BANKS; b++)
            if (rv[b]) rd_data = rd_data | rd[b];
    end

    always_ff @(posedge clk) begin
        if (rst)        conflict_cnt <= '0;
        else if (stall) conflict_cnt <= conflict_cnt + CONF_W'(1);
    end

    assert_one_reader_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rv));
    assert_read_follows_R4: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(req_valid && req_ready && !req_we && loc.in_range));
    assert_count_stall_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (conflict_cnt == $past(conflict_cnt) + CONF_W'(1)));
    assert_range_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        range_err |=> !rd_valid);
    assert_range_ready_R8: assert property (@(posedge clk) disable iff (rst)
        range_err |-> req_ready);
endmodule

// File: tb/prime_bank_mapper_tb_top.sv
module prime_bank_mapper_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_we = 1'b0;
    logic [4:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, range_err, rd_valid;
    logic [1:0]  map_bank;
    logic [2:0]  map_offset;
    logic [15:0] rd_data, conflict_cnt;

    int          total = 0, bad = 0, stalls = 0;
    logic [15:0] model [24];
    logic [15:0] exp_q [$];

    always #10 clk = ~clk;

    prime_bank_mapper dut_i (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // driver: called at a falling edge, returns at the falling edge after acceptance
    task automatic issue(input bit we, input int a, input logic [15:0] d);
        req_valid = 1'b1; req_we = we; req_addr = 5'(a); req_wdata = d;
        #1;
        while (!req_ready) begin
            stalls++;
            @(negedge clk); #1;
        end
        if (a < 24) begin
            if (we) model[a] = d;
            else    exp_q.push_back(model[a]);
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // monitor: compares returned read data against the queue
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) check(1'b0, "R4 unexpected rd_valid", 1, 0);
            else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                check(rd_data == e, "R2/R4 read data", int'(rd_data), int'(e));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int c0, s0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1, "R9 ready after reset", int'(req_ready), 1);
        check(rd_valid == 1'b0, "R9 rd_valid after reset", int'(rd_valid), 0);
        check(conflict_cnt == 0, "R9 conflict_cnt after reset", int'(conflict_cnt), 0);

        // mapping, R1 and R2
        for (int a = 0; a < 24; a++) begin
            req_addr = 5'(a); #1;
            check(int'(map_bank) == a % 3, "R1 bank", int'(map_bank), a % 3);
            check(int'(map_offset) == a % 8, "R2 offset", int'(map_offset), a % 8);
        end
        req_addr = 5'd5; #1;
        check(map_bank == 2'd2 && map_offset == 3'd5, "R3 address 5",
              int'(map_bank) * 10 + int'(map_offset), 25);
        @(negedge clk);

        // fill all words, read back (R2 uniqueness)
        for (int a = 0; a < 24; a++) issue(1'b1, a, 16'(16'h1000 + a * 37));
        for (int a = 0; a < 24; a++) issue(1'b0, a, 16'h0);
        idle(4);
        check(exp_q.size() == 0, "R4 all reads returned", exp_q.size(), 0);

        // R5: immediate refusal on same bank
        issue(1'b1, 0, 16'hAAAA);
        req_valid = 1'b1; req_we = 1'b0; req_addr = 5'd3; #1;
        check(req_ready == 1'b0, "R5 busy bank refused", int'(req_ready), 0);
        req_valid = 1'b0;
        idle(4);

        // R7 stride-1
        c0 = int'(conflict_cnt); s0 = stalls;
        for (int i = 0; i < 12; i++) issue(1'b0, i, 16'h0);
        check(stalls - s0 == 0, "R7 stride-1 refusals", stalls - s0, 0);
        check(int'(conflict_cnt) - c0 == 0, "R6 stride-1 count", int'(conflict_cnt) - c0, 0);
        idle(4);

        // R7 stride-8 modulo 24
        c0 = int'(conflict_cnt); s0 = stalls;
        for (int i = 0; i < 9; i++) issue(1'b0, (i * 8) % 24, 16'h0);
        check(stalls - s0 == 0, "R7 stride-8 refusals", stalls - s0, 0);
        check(int'(conflict_cnt) - c0 == 0, "R6 stride-8 count", int'(conflict_cnt) - c0, 0);
        idle(4);

        // R7 stride-3, same bank
        c0 = int'(conflict_cnt); s0 = stalls;
        for (int i = 0; i < 4; i++) issue(1'b0, i * 3, 16'h0);
        check(stalls - s0 == 6, "R7 stride-3 refusals", stalls - s0, 6);
        check(int'(conflict_cnt) - c0 == 6, "R6 stride-3 count", int'(conflict_cnt) - c0, 6);
        idle(4);

        // R8 out of range
        req_valid = 1'b1; req_we = 1'b1; req_addr = 5'd29; req_wdata = 16'hDEAD; #1;
        check(range_err == 1'b1, "R8 range_err", int'(range_err), 1);
        check(req_ready == 1'b1, "R8 ready kept high", int'(req_ready), 1);
        @(negedge clk);
        s0 = stalls;
        issue(1'b0, 2, 16'h0);
        check(stalls - s0 == 0, "R8 bank not occupied", stalls - s0, 0);
        idle(4);
        issue(1'b0, 27, 16'h0);
        check(rd_valid == 1'b0, "R8 no read data", int'(rd_valid), 0);
        issue(1'b0, 5, 16'h0);
        idle(4);
        check(exp_q.size() == 0, "R8 word 5 read back", exp_q.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule